// File: doc/BRIEF.md
# Buffered SPI Master

This block is a memory-mapped SPI master for a 32-bit register port. Software writes bytes into a transmit queue through a data register and sets a run bit. A shift engine then sends each queued byte MSB first on MOSI while it samples MISO, and it stores each received byte in a receive queue. Both queues are 16 bytes deep, so software moves data in bursts. It is paced by a "receive queue needs draining" flag, an "all sent" flag and one level-sensitive interrupt. The engine supports all four SPI clock modes and three chip-select lines with per-line polarity. A select code that drives no line at all is also available.

The shift engine is a three-state machine. IDLE waits while the run bit is clear or the transmit queue is empty. IDLE→LEAD fires when the run bit is set and a byte is queued; this transition pops the byte. LEAD is the first half of a bit period: the bit is already on MOSI and SCLK sits at CPHA xor CPOL. LEAD→TRAIL fires when the half-period count expires, and MISO is sampled on that transition. TRAIL is the second half of the bit. TRAIL→LEAD fires after the half period when more bits remain, and the next bit is shifted onto MOSI. TRAIL→IDLE fires after the eighth bit and pushes the received byte. Any state→IDLE fires as soon as the run bit is cleared, and the partial byte is abandoned.

Register words are selected by `reg_addr[3:2]`. Word 0 is control/status, word 1 is the data queue, word 2 is the clock divider and word 3 is the length word.

Top module: `spi_fifo_master`

## Requirements
- R1: The divider word (16 bits, word 2) and the length word (16 bits, word 3) read back what was written. Control word fields read back at these bits: select code [1:0], CPHA [2], CPOL [3], common select polarity [6], run [7], done-interrupt enable [9], threshold-interrupt enable [10], line polarity [23:21]. Every other control bit reads 0. Read data appears on `reg_rdata` one clock after the access.
- R2: The SCLK period is the divider value in core clocks. A value of 0 means 65536, and values below 2 give a period of 2. Queued bytes leave MSB first.
- R3: A data-port write while the transmit queue holds 16 bytes is dropped. A data-port read of an empty receive queue returns 0.
- R4: Each completed byte pushes the 8 bits sampled from MISO into the receive queue, in arrival order and MSB first.
- R5: SCLK rests at CPOL while idle. A bit is placed on MOSI at the start of its first half, and MISO is sampled at the start of its second half. During the first half SCLK equals CPHA xor CPOL. MOSI never changes while SCLK is steady during a byte.
- R6: While run is set, a select code of 0, 1 or 2 drives that line to its active level and the others to their inactive level. Code 3 drives none. A line's active level is high when its polarity bit or the common bit is 1. With run clear, all lines are inactive.
- R7: Writing 1 to control bit 4 empties the transmit queue, and writing 1 to bit 5 empties the receive queue. Both bits read back 0.
- R8: Status bit 16 (done) is 1 exactly when run is set, the transmit queue is empty and no byte is shifting. It is 1 right after run is set with an empty queue.
- R9: Status bit 17 is 1 when the receive queue is non-empty. Bit 18 is 1 when the transmit queue is not full. Bit 19 is 1 when the receive queue holds 12 or more bytes. Bit 20 is 1 when the receive queue is full.
- R10: `irq` = (done and the done-interrupt enable) or (bit 19 and the threshold-interrupt enable), as a level.
- R11: Clearing run mid-byte returns the engine to IDLE on the next clock, with SCLK at CPOL and the select lines inactive. The partial byte is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte address; bits 3:2 pick the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one clock after the access |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 3 | Chip-select line levels |
| irq | output | 1 | Level interrupt |

## Verification
Every cycle, the checker confirms several properties. SCLK rests at CPOL whenever the engine is idle. MOSI holds still while SCLK is steady. At most one select line is active, and none is active with run clear. The engine is idle one clock after run falls. A write to a full transmit queue never grows it. The interrupt stays low with both enables clear and follows done and the threshold level. Only the bench's scenarios can show several other behaviours: the bit order and edge placement in each of the four modes, the divider periods (including the 0 = 65536 case), the drop of the seventeenth byte, the threshold at 12 bytes, the flush bits, and the zero returned from an empty queue.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    typedef enum logic [1:0] {SH_IDLE, SH_LEAD, SH_TRAIL} sh_state_t;

    localparam logic [1:0] W_CTRL = 2'd0;
    localparam logic [1:0] W_DATA = 2'd1;
    localparam logic [1:0] W_DIV  = 2'd2;
    localparam logic [1:0] W_LEN  = 2'd3;

    localparam int B_CPHA    = 2;
    localparam int B_CPOL    = 3;
    localparam int B_TXCLR   = 4;
    localparam int B_RXCLR   = 5;
    localparam int B_CSPOL   = 6;
    localparam int B_RUN     = 7;
    localparam int B_IEDONE  = 9;
    localparam int B_IERX    = 10;
    localparam int B_DONE    = 16;
    localparam int B_RXD     = 17;
    localparam int B_TXD     = 18;
    localparam int B_RXR     = 19;
    localparam int B_RXF     = 20;
    localparam int B_LPOL    = 21;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_fifo_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 16,
    localparam int BC_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  half_m1,
    input  logic              tx_avail,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sclk_phase,
    output logic              mosi,
    output logic              busy
);
    sh_state_t         state_q, state_d;
    logic [DIV_W-1:0]  cnt_q;
    logic [BC_W-1:0]   bit_q;
    logic [BYTE_W-1:0] tx_sh, rx_sh;
    logic              half_end, last_bit;

    assign half_end = (cnt_q == half_m1);
    assign last_bit = (bit_q == BC_W'(BYTE_W-1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE:  if (enable && tx_avail) state_d = SH_LEAD;
            SH_LEAD:  if (half_end) state_d = SH_TRAIL;
            SH_TRAIL: if (half_end) state_d = last_bit ? SH_IDLE : SH_LEAD;
            default:  state_d = SH_IDLE;
        endcase
        if (!enable) state_d = SH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == SH_IDLE || state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (state_q == SH_IDLE && state_d == SH_LEAD) begin
                tx_sh <= tx_byte;
                bit_q <= '0;
            end
            if (state_q == SH_LEAD && state_d == SH_TRAIL)
                rx_sh <= {rx_sh[BYTE_W-2:0], miso};
            if (state_q == SH_TRAIL && state_d == SH_LEAD) begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy       = (state_q != SH_IDLE);
        tx_pop     = (state_q == SH_IDLE) && (state_d == SH_LEAD);
        rx_push    = (state_q == SH_TRAIL) && enable && half_end && last_bit;
        rx_byte    = rx_sh;
        mosi       = busy ? tx_sh[BYTE_W-1] : 1'b0;
        unique case (state_q)
            SH_LEAD:  sclk_phase = cpha;
            SH_TRAIL: sclk_phase = ~cpha;
            default:  sclk_phase = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_fifo_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int NUM_CS     = 3,
    parameter int DIV_W      = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1,
    localparam int RXR_LEVEL = FIFO_DEPTH * 3 / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_o,
    output logic              irq
);
    logic [1:0]        ctl_csel;
    logic              ctl_cpha, ctl_cpol, ctl_cspol, ctl_ta, ctl_intd, ctl_intr;
    logic [NUM_CS-1:0] ctl_linepol;
    logic [DIV_W-1:0]  div_q;
    logic [15:0]       len_q;

    logic [1:0]        word;
    logic              wr_ctl, wr_data, rd_data;
    logic [7:0]        tx_head, rx_head, rx_byte;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              tx_pop, rx_push, busy, sclk_phase, done, rxr;
    logic [DIV_W:0]    period;
    logic [DIV_W-1:0]  half, half_m1;
    logic [31:0]       ctl_view;

    assign word    = reg_addr[3:2];
    assign wr_ctl  = reg_en && reg_we && (word == W_CTRL);
    assign wr_data = reg_en && reg_we && (word == W_DATA);
    assign rd_data = reg_en && !reg_we && (word == W_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_csel <= '0; ctl_cpha <= 1'b0; ctl_cpol <= 1'b0; ctl_cspol <= 1'b0;
            ctl_ta <= 1'b0; ctl_intd <= 1'b0; ctl_intr <= 1'b0;
            ctl_linepol <= '0; div_q <= '0; len_q <= '0;
        end else if (reg_en && reg_we) begin
            unique case (word)
                W_CTRL: begin
                    ctl_csel    <= reg_wdata[1:0];
                    ctl_cpha    <= reg_wdata[B_CPHA];
                    ctl_cpol    <= reg_wdata[B_CPOL];
                    ctl_cspol   <= reg_wdata[B_CSPOL];
                    ctl_ta      <= reg_wdata[B_RUN];
                    ctl_intd    <= reg_wdata[B_IEDONE];
                    ctl_intr    <= reg_wdata[B_IERX];
                    ctl_linepol <= reg_wdata[B_LPOL +: NUM_CS];
                end
                W_DIV:   div_q <= reg_wdata[DIV_W-1:0];
                W_LEN:   len_q <= reg_wdata[15:0];
                default: ;
            endcase
        end
    end

    spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(wr_ctl && reg_wdata[B_TXCLR]),
        .push(wr_data), .wdata(reg_wdata[7:0]), .pop(tx_pop), .rdata(tx_head),
        .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(wr_ctl && reg_wdata[B_RXCLR]),
        .push(rx_push), .wdata(rx_byte), .pop(rd_data), .rdata(rx_head),
        .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    assign period  = (div_q == '0) ? (DIV_W+1)'(1) << DIV_W : {1'b0, div_q};
    assign half    = period[DIV_W:1];
    assign half_m1 = (half == '0) ? '0 : half - 1'b1;

    spi_shift_engine #(.BYTE_W(8), .DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .enable(ctl_ta), .cpha(ctl_cpha), .half_m1(half_m1),
        .tx_avail(!tx_empty), .tx_byte(tx_head), .miso(miso), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte), .sclk_phase(sclk_phase), .mosi(mosi),
        .busy(busy)
    );

    assign sclk = sclk_phase ^ ctl_cpol;
    assign done = ctl_ta && tx_empty && !busy;
    assign rxr  = (rx_count >= CNT_W'(RXR_LEVEL));
    assign irq  = (done && ctl_intd) || (rxr && ctl_intr);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        logic act_lvl;
        assign act_lvl = ctl_linepol[i] | ctl_cspol;
        assign cs_o[i] = (ctl_ta && ctl_csel == 2'(i)) ? act_lvl : ~act_lvl;
    end

    always_comb begin
        ctl_view                      = '0;
        ctl_view[1:0]                 = ctl_csel;
        ctl_view[B_CPHA]              = ctl_cpha;
        ctl_view[B_CPOL]              = ctl_cpol;
        ctl_view[B_CSPOL]             = ctl_cspol;
        ctl_view[B_RUN]               = ctl_ta;
        ctl_view[B_IEDONE]            = ctl_intd;
        ctl_view[B_IERX]              = ctl_intr;
        ctl_view[B_DONE]              = done;
        ctl_view[B_RXD]               = !rx_empty;
        ctl_view[B_TXD]               = !tx_full;
        ctl_view[B_RXR]               = rxr;
        ctl_view[B_RXF]               = rx_full;
        ctl_view[B_LPOL +: NUM_CS]    = ctl_linepol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_en && !reg_we) begin
            unique case (word)
                W_CTRL:  reg_rdata <= ctl_view;
                W_DATA:  reg_rdata <= {24'b0, rx_head};
                W_DIV:   reg_rdata <= 32'(div_q);
                default: reg_rdata <= {16'b0, len_q};
            endcase
        end
    end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
    parameter int NUM_CS     = 3,
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1,
    localparam int RXR_LEVEL = FIFO_DEPTH * 3 / 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ta,
    input logic              cpol,
    input logic              cspol,
    input logic [NUM_CS-1:0] linepol,
    input logic              busy,
    input logic              sclk,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_o,
    input logic              irq,
    input logic              intd,
    input logic              intr,
    input logic              tx_empty,
    input logic              reg_en,
    input logic              reg_we,
    input logic [3:0]        reg_addr,
    input logic              tx_full,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count
);
    logic [NUM_CS-1:0] idle_lvl;
    assign idle_lvl = ~(linepol | {NUM_CS{cspol}});

    p_cs_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ta |-> cs_o == idle_lvl);
    p_cs_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o ^ idle_lvl));
    p_sclk_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == cpol);
    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(sclk)) |-> $stable(mosi));
    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ta) |=> !busy);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && reg_addr[3:2] == 2'd1 && tx_full) |=> tx_count <= $past(tx_count));
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!intd && !intr) |-> !irq);
    p_done_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ta && intd && tx_empty && !busy) |-> irq);
    p_level_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (intr && rx_count >= CNT_W'(RXR_LEVEL)) |-> irq);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.NUM_CS(NUM_CS), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ta(ctl_ta), .cpol(ctl_cpol), .cspol(ctl_cspol),
    .linepol(ctl_linepol), .busy(busy), .sclk(sclk), .mosi(mosi), .cs_o(cs_o),
    .irq(irq), .intd(ctl_intd), .intr(ctl_intr), .tx_empty(tx_empty),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .tx_full(tx_full),
    .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/tb_spi_fifo_master.sv
`timescale 1ns/1ps
module tb_spi_fifo_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso;
    logic [2:0]  cs_o;
    logic        irq;
    logic        miso_inv = 1'b0;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, last_rise = 0, last_period = 0, rise_n = 0;
    logic prev_sclk = 1'b0;
    logic samp_lvl = 1'b1;
    logic [7:0] cap_sh = '0;
    int cap_bits = 0, cap_n = 0;
    logic [7:0] cap_mem [32];
    logic [7:0] exp_b [32];

    always #2 clk = ~clk;
    assign miso = mosi ^ miso_inv;

    spi_fifo_master dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_o(cs_o), .irq(irq)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sclk !== prev_sclk) begin
            if (sclk == samp_lvl) begin
                cap_sh = {cap_sh[6:0], mosi};
                cap_bits = cap_bits + 1;
                if (cap_bits == 8) begin
                    if (cap_n < 32) cap_mem[cap_n] = cap_sh;
                    cap_n = cap_n + 1;
                    cap_bits = 0;
                end
            end
            if (sclk == 1'b1) begin
                last_period = cyc - last_rise;
                last_rise = cyc;
                rise_n = rise_n + 1;
            end
        end
        prev_sclk = sclk;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog: run did not finish (act timeout, exp completion)");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(posedge clk); #1;
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_ctl(input logic [1:0] csel, input logic cpha, input logic cpol,
                                           input logic run, input logic ied, input logic ier,
                                           input logic cp, input logic [2:0] lp);
        logic [31:0] v = '0;
        v[1:0] = csel; v[2] = cpha; v[3] = cpol; v[6] = cp; v[7] = run;
        v[9] = ied; v[10] = ier; v[23:21] = lp;
        return v;
    endfunction

    function automatic int eff_period(input int div);
        int h;
        h = (div == 0) ? 32768 : div / 2;
        if (h == 0) h = 1;
        return 2 * h;
    endfunction

    function automatic logic [2:0] exp_cs(input logic run, input logic [1:0] csel, input logic cp, input logic [2:0] lp);
        logic [2:0] v;
        for (int i = 0; i < 3; i++) begin
            v[i] = ~(lp[i] | cp);
            if (run && csel == 2'(i)) v[i] = lp[i] | cp;
        end
        return v;
    endfunction

    task automatic wait_done();
        logic [31:0] s;
        for (int k = 0; k < 4000; k++) begin
            reg_rd(4'h0, s);
            if (s[16]) break;
        end
    endtask

    task automatic run_xfer(input int n, input logic cpha, input logic cpol, input logic [1:0] csel,
                            input int div, input logic inv, input logic cp, input logic [2:0] lp);
        logic [31:0] r;
        reg_wr(4'h8, 32'(div));
        reg_wr(4'h0, mk_ctl(csel, cpha, cpol, 1'b0, 1'b0, 1'b0, cp, lp));
        check(cs_o == exp_cs(1'b0, csel, cp, lp), "R6 idle select lines", 32'(cs_o), 32'(exp_cs(1'b0, csel, cp, lp)));
        samp_lvl = ~cpha ^ cpol;
        miso_inv = inv;
        repeat (2) @(posedge clk);
        cap_n = 0; cap_bits = 0;
        for (int i = 0; i < n; i++) begin
            exp_b[i] = 8'($urandom);
            reg_wr(4'h4, 32'(exp_b[i]));
        end
        reg_wr(4'h0, mk_ctl(csel, cpha, cpol, 1'b1, 1'b0, 1'b0, cp, lp));
        check(cs_o == exp_cs(1'b1, csel, cp, lp), "R6 active select lines", 32'(cs_o), 32'(exp_cs(1'b1, csel, cp, lp)));
        wait_done();
        check(cap_n == n, "R2 bytes shifted out", 32'(cap_n), 32'(n));
        for (int i = 0; i < n; i++)
            check(cap_mem[i] == exp_b[i], "R5 MOSI byte MSB first", 32'(cap_mem[i]), 32'(exp_b[i]));
        check(last_period == eff_period(div), "R2 SCLK period", 32'(last_period), 32'(eff_period(div)));
        for (int i = 0; i < n; i++) begin
            reg_rd(4'h4, r);
            check(r[7:0] == (exp_b[i] ^ {8{inv}}), "R4 received byte", r, 32'(exp_b[i] ^ {8{inv}}));
        end
        reg_wr(4'h0, mk_ctl(csel, cpha, cpol, 1'b0, 1'b0, 1'b0, cp, lp));
        check(sclk == cpol, "R5 SCLK rest level", 32'(sclk), 32'(cpol));
    endtask

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5A17));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // reset state
        check(cs_o == 3'b111 && sclk == 1'b0 && irq == 1'b0, "R6 reset outputs", {cs_o, sclk, irq}, 32'b11100);
        reg_rd(4'h0, r);
        check(r == 32'h0004_0000, "R9 reset status", r, 32'h0004_0000);

        // R1 register read-back
        reg_wr(4'h8, 32'hFFFF_1234);
        reg_rd(4'h8, r);
        check(r == 32'h1234, "R1 divider read-back", r, 32'h1234);
        reg_wr(4'hC, 32'h0000_BEEF);
        reg_rd(4'hC, r);
        check(r == 32'hBEEF, "R1 length read-back", r, 32'hBEEF);
        reg_wr(4'h0, 32'h00E0_067D);
        reg_rd(4'h0, r);
        check(r == 32'h00E4_064D, "R1 control read-back", r, 32'h00E4_064D);
        reg_wr(4'h0, 32'h0);

        // R8 / R10 done raised right after run with empty queue
        reg_wr(4'h8, 32'd8);
        reg_wr(4'h0, mk_ctl(2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b0));
        check(irq == 1'b1, "R10 irq from done", 32'(irq), 32'd1);
        reg_rd(4'h0, r);
        check(r[16] == 1'b1, "R8 done with empty queue", r, 32'h1_0000);
        reg_wr(4'h4, 32'hA5);
        reg_rd(4'h0, r);
        check(r[16] == 1'b0, "R8 done low while shifting", r, 32'h0);
        wait_done();
        check(irq == 1'b1, "R8 done high after byte", 32'(irq), 32'd1);
        reg_rd(4'h4, r);
        reg_wr(4'h0, 32'h0);

        // R3 / R9 / R10 full queue and threshold
        cap_n = 0; cap_bits = 0; samp_lvl = 1'b1; miso_inv = 1'b0;
        reg_wr(4'h8, 32'd2);
        for (int i = 1; i <= 17; i++) reg_wr(4'h4, 32'(i));
        reg_rd(4'h0, r);
        check(r[18] == 1'b0, "R9 transmit full flag", r, 32'h0);
        reg_wr(4'h0, mk_ctl(2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b0));
        wait_done();
        check(cap_n == 16, "R3 seventeenth byte dropped", 32'(cap_n), 32'd16);
        check(cap_mem[15] == 8'd16, "R3 last byte sent", 32'(cap_mem[15]), 32'd16);
        reg_rd(4'h0, r);
        check(r[20:19] == 2'b11, "R9 full and threshold", r, 32'h0018_0000);
        check(irq == 1'b1, "R10 irq from threshold", 32'(irq), 32'd1);
        for (int i = 0; i < 4; i++) reg_rd(4'h4, r);
        reg_rd(4'h0, r);
        check(r[19] == 1'b1, "R9 threshold at 12", r, 32'h8_0000);
        reg_rd(4'h4, r);
        check(r == 32'd5, "R4 fifth byte", r, 32'd5);
        reg_rd(4'h0, r);
        check(r[19] == 1'b0 && r[17] == 1'b1, "R9 below threshold at 11", r, 32'h2_0000);
        check(irq == 1'b0, "R10 irq released", 32'(irq), 32'd0);
        for (int i = 0; i < 11; i++) reg_rd(4'h4, r);
        reg_rd(4'h4, r);
        check(r == 32'd0, "R3 empty read returns zero", r, 32'd0);
        reg_wr(4'h0, 32'h0);

        // R7 flush bits
        cap_n = 0; cap_bits = 0;
        for (int i = 0; i < 3; i++) reg_wr(4'h4, 32'h3C);
        reg_wr(4'h0, 32'h10);
        reg_wr(4'h0, mk_ctl(2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b0));
        check(irq == 1'b1, "R7 transmit queue emptied", 32'(irq), 32'd1);
        repeat (40) @(posedge clk);
        #1 check(cap_n == 0, "R7 nothing shifted after flush", 32'(cap_n), 32'd0);
        reg_wr(4'h4, 32'h11);
        reg_wr(4'h4, 32'h22);
        wait_done();
        reg_wr(4'h0, 32'h30);
        reg_rd(4'h0, r);
        check(r[17] == 1'b0 && r[5:4] == 2'b00, "R7 receive flush and self-clear", r, 32'h0);

        // R6 select codes and polarities
        run_xfer(2, 1'b0, 1'b0, 2'd3, 4, 1'b0, 1'b0, 3'b000);
        run_xfer(2, 1'b0, 1'b0, 2'd1, 4, 1'b1, 1'b0, 3'b010);
        run_xfer(2, 1'b1, 1'b1, 2'd2, 2, 1'b0, 1'b1, 3'b000);
        run_xfer(3, 1'b0, 1'b0, 2'd0, 1, 1'b0, 1'b0, 3'b000);

        // randomized transfers over all modes
        for (int k = 0; k < 8; k++) begin
            int n, dv;
            n  = 1 + int'($urandom % 8);
            dv = 2 * (1 + int'($urandom % 3));
            run_xfer(n, 1'($urandom), 1'($urandom), 2'($urandom), dv, 1'($urandom),
                     1'($urandom), 3'($urandom));
        end

        // R2 divider zero and R11 abort mid-byte
        reg_wr(4'h8, 32'd0);
        reg_wr(4'h0, 32'h0);
        reg_wr(4'h4, 32'hC3);
        rise_n = 0;
        reg_wr(4'h0, mk_ctl(2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b0));
        while (rise_n < 2) @(posedge clk);
        #1 check(last_period == 65536, "R2 divider zero period", 32'(last_period), 32'd65536);
        reg_wr(4'h0, 32'h0);
        @(posedge clk); #1;
        check(sclk == 1'b0 && cs_o == 3'b111, "R11 abort to idle", {cs_o, sclk}, 32'b1110);
        reg_rd(4'h0, r);
        check(r[17] == 1'b0, "R11 partial byte not stored", r, 32'h0);

        summary();
        $finish;
    end
endmodule